// File: doc/BRIEF.md
# Fractional Predivider Clock Generator

This block derives a slow clock from one of three faster source clocks, for uses such as a display pixel clock or an audio master clock. Every source arrives as a one-cycle tick in the system clock domain, where one tick stands for one source cycle. The selected ticks pass through a predivider that divides by 2, 2.5 or 3, and then through an integer divider that divides by 1 to 127. The result is the output clock, given as a one-cycle pulse `clk_pulse` at the end of each output period. Its frequency is 2·f_src / ((code+3)·N), where code is the predivide code and N is the divide value.

Settings come from a single 32-bit control word, which is written through `cfg_we`/`cfg_wdata` and read back on `cfg_rdata`. A controller with three states owns the live settings. In `ST_OFF` the counters are cleared. It moves to `ST_RUN` as soon as the stored word is valid, loading the settings on that move. In `ST_RUN` the counters run and pulses are produced. It moves to `ST_HOLD` when the stored settings differ from the live ones while a period is still in progress. In `ST_HOLD` the counters go on with the old settings and no pulse is produced. It returns to `ST_RUN` when that period ends, loading the new settings at that point. If the settings change in the very cycle a period ends, it reloads and stays in `ST_RUN` without a pulse. From `ST_RUN` or `ST_HOLD` it moves to `ST_OFF` as soon as the stored word becomes invalid.

Top module: `frac_clkgen`

## Requirements
- R1: A cycle with `cfg_we` high stores all 32 bits of `cfg_wdata`, reserved bit 7 included. The stored word appears on `cfg_rdata` after that clock edge.
- R2: The output runs only when bit 15 is 1, bits [9:8] are nonzero and bits [6:0] are nonzero. If any of these fails, `clk_pulse` stays low. After a write that makes the word invalid, no pulse appears later than one clock edge after the write edge.
- R3: Bits [14:13] choose the source: 00 and 01 choose `src_tick[0]`, 10 chooses `src_tick[1]` and 11 chooses `src_tick[2]`. Only ticks of the chosen source advance the counters.
- R4: Predivide code 1 (bits [9:8]) makes one predivided step from 2 source ticks. Code 3 makes one step from 3 ticks.
- R5: Predivide code 2 makes steps of 2 and 3 ticks in turn, starting with 2 after each load. The alternation carries on across output periods, so with divide 1 the output intervals alternate between 2 and 3 ticks.
- R6: A divide value N makes one output period from N predivided steps. `clk_pulse` is high for one cycle, in the cycle after the edge where the tick that closes the period is taken.
- R7: When the block starts from the off state, the first clock edge that sees a valid word only loads the settings. With code 1, divide 1 and a tick in every cycle, the first pulse is visible three edges after the write edge.
- R8: A change to the source, predivide or divide setting while the block runs suppresses the closing pulse of the current period. The new settings take effect with fresh counters at that period boundary. A change between source codes 00 and 01, or a change to bits outside the fields, is not a change.
- R9: After reset the stored word is zero, the controller is off and `clk_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word to store |
| cfg_rdata | output | 32 | Stored control word |
| src_tick | input | 3 | One tick per source cycle, per source |
| clk_pulse | output | 1 | One-cycle pulse at each output period end |

## Verification
The three sources tick at different rates: every cycle, every second cycle and every third cycle. The measured output intervals therefore show which source is counted, and they also separate predivide codes 1, 2 and 3 and different divide values. Divide 1 with the 2.5 predivide shows whether the 2/3 alternation carries across periods. Rewrites are issued just after a pulse, and they tell apart three cases: a real change, which must cost one suppressed pulse; a change between codes 00 and 01 or of bit 7, which must not; and a disabling write, which must silence the output.

// File: rtl/frac_clkgen_pkg.sv
package frac_clkgen_pkg;

    localparam int CG_DIV_W    = 7;
    localparam int CG_EN_BIT   = 15;
    localparam int CG_SEL_LSB  = 13;
    localparam int CG_PD_LSB   = 8;
    localparam int CG_DIV_LSB  = 0;

    // predivide codes
    localparam logic [1:0] CG_PD_OFF   = 2'd0;
    localparam logic [1:0] CG_PD_TWO   = 2'd1;
    localparam logic [1:0] CG_PD_HALF  = 2'd2;
    localparam logic [1:0] CG_PD_THREE = 2'd3;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } cg_state_e;

    typedef struct packed {
        logic [1:0]          src;
        logic [1:0]          pdiv;
        logic [CG_DIV_W-1:0] div;
    } cg_set_t;

    function automatic logic [1:0] cg_src_index(input logic [1:0] sel);
        if (sel[1]) return sel[0] ? 2'd2 : 2'd1;
        return 2'd0;
    endfunction

endpackage

// File: rtl/clkgen_cfg_reg.sv
module clkgen_cfg_reg
    import frac_clkgen_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] word_q,
    output cg_set_t          set_o,
    output logic             valid_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  word_q <= '0;
        else if (we) word_q <= wdata;
    end

    always_comb begin
        set_o.src  = cg_src_index(word_q[CG_SEL_LSB +: 2]);
        set_o.pdiv = word_q[CG_PD_LSB +: 2];
        set_o.div  = word_q[CG_DIV_LSB +: CG_DIV_W];
        valid_o    = word_q[CG_EN_BIT] && (set_o.pdiv != CG_PD_OFF) && (set_o.div != '0);
    end

    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (word_q == $past(wdata)));

endmodule

// File: rtl/clkgen_prediv.sv
module clkgen_prediv
    import frac_clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick,
    input  logic [1:0] mode,
    output logic       step
);

    logic [1:0] cnt;
    logic       phase;
    logic [1:0] last;

    always_comb begin
        last = ((mode == CG_PD_THREE) || ((mode == CG_PD_HALF) && phase)) ? 2'd2 : 2'd1;
        step = tick && (cnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (clr) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (tick) begin
            if (cnt == last) begin
                cnt <= '0;
                if (mode == CG_PD_HALF) phase <= ~phase;
            end else begin
                cnt <= cnt + 2'd1;
            end
        end
    end

    assert_prediv_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode != CG_PD_THREE) && !((mode == CG_PD_HALF) && phase)) |-> (cnt <= 2'd1));

    assert_phase_only_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != CG_PD_HALF) |-> !phase);

endmodule

// File: rtl/clkgen_intdiv.sv
module clkgen_intdiv #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [DIV_W-1:0] div,
    output logic             per_end
);

    logic [DIV_W-1:0] cnt;

    assign per_end = step && (cnt == div - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (clr)      cnt <= '0;
        else if (step)     cnt <= per_end ? '0 : cnt + 1'b1;
    end

    assert_div_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (div != '0) |-> (cnt < div));

endmodule

// File: rtl/frac_clkgen.sv
module frac_clkgen
    import frac_clkgen_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int NSRC  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic [NSRC-1:0]  src_tick,
    output logic             clk_pulse
);

    cg_state_e state, state_nxt;
    cg_set_t   cfg_set, act;
    logic      cfg_valid;
    logic      changed, reload, pulse_d, clr;
    logic      tick_g, step, per_end;

    clkgen_cfg_reg #(.REG_W(REG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .word_q  (cfg_rdata),
        .set_o   (cfg_set),
        .valid_o (cfg_valid)
    );

    assign tick_g  = (state != ST_OFF) && src_tick[act.src];
    assign changed = (cfg_set != act);
    assign clr     = reload || (state == ST_OFF);

    clkgen_prediv u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .tick  (tick_g),
        .mode  (act.pdiv),
        .step  (step)
    );

    clkgen_intdiv #(.DIV_W(CG_DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .step    (step),
        .div     (act.div),
        .per_end (per_end)
    );

    // state register and live settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_OFF;
            act       <= '0;
            clk_pulse <= 1'b0;
        end else begin
            state     <= state_nxt;
            clk_pulse <= pulse_d;
            if (reload) act <= cfg_set;
        end
    end

    // next state and outputs
    always_comb begin
        state_nxt = state;
        reload    = 1'b0;
        pulse_d   = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (cfg_valid) begin
                    reload    = 1'b1;
                    state_nxt = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!cfg_valid) begin
                    state_nxt = ST_OFF;
                end else if (changed) begin
                    if (per_end) reload    = 1'b1;
                    else         state_nxt = ST_HOLD;
                end else begin
                    pulse_d = per_end;
                end
            end
            ST_HOLD: begin
                if (!cfg_valid) begin
                    state_nxt = ST_OFF;
                end else if (per_end) begin
                    reload    = 1'b1;
                    state_nxt = ST_RUN;
                end
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    assert_off_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !clk_pulse);

    assert_invalid_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> (state == ST_OFF));

    assert_hold_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !clk_pulse);

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_pulse |=> !clk_pulse);

endmodule

// File: tb/frac_clkgen_bench.sv
`timescale 1ns/1ps
module frac_clkgen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [2:0]  src_tick = 3'b000;
    logic        clk_pulse;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit live = 1'b0;
    int cyc = 0;

    always #5 clk = ~clk;

    frac_clkgen u_frac_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .src_tick  (src_tick),
        .clk_pulse (clk_pulse)
    );

    // source ticks: every cycle, every 2nd, every 3rd
    always @(negedge clk) begin
        cyc <= cyc + 1;
        src_tick[0] <= 1'b1;
        src_tick[1] <= (cyc % 2 == 0);
        src_tick[2] <= (cyc % 3 == 0);
    end

    // behavioural reference model
    logic [31:0] m_reg;
    int m_st, m_src, m_pd, m_dv, m_pc, m_ph, m_dc, nst, n_src, n_pd, n_dv, plen;
    bit m_pulse, ok, chg, tk, stp, e, rl;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reg = '0; m_st = 0; m_src = 0; m_pd = 0; m_dv = 0;
            m_pc = 0; m_ph = 0; m_dc = 0; m_pulse = 0;
        end else begin
            n_src = (m_reg[14:13] == 2'b11) ? 2 : (m_reg[14:13] == 2'b10) ? 1 : 0;
            n_pd  = int'(m_reg[9:8]);
            n_dv  = int'(m_reg[6:0]);
            ok    = m_reg[15] && n_pd != 0 && n_dv != 0;
            chg   = (n_src != m_src) || (n_pd != m_pd) || (n_dv != m_dv);
            tk    = (m_st != 0) && src_tick[m_src];
            plen  = (m_pd == 3 || (m_pd == 2 && m_ph == 1)) ? 3 : 2;
            stp   = tk && (m_pc == plen - 1);
            e     = stp && (m_dc == m_dv - 1);
            rl = 0; nst = m_st; m_pulse = 0;
            if (m_st == 0) begin
                if (ok) begin rl = 1; nst = 1; end
            end else if (!ok) begin
                nst = 0;
            end else if (m_st == 1) begin
                if (chg) begin
                    if (e) rl = 1; else nst = 2;
                end else m_pulse = e;
            end else if (e) begin
                rl = 1; nst = 1;
            end
            if (tk) begin
                if (stp) begin
                    m_pc = 0;
                    if (m_pd == 2) m_ph = 1 - m_ph;
                    if (e) m_dc = 0; else m_dc = m_dc + 1;
                end else m_pc = m_pc + 1;
            end
            if (rl) begin
                m_src = n_src; m_pd = n_pd; m_dv = n_dv;
                m_pc = 0; m_ph = 0; m_dc = 0;
            end
            m_st = nst;
            if (cfg_we) m_reg = cfg_wdata;
        end
    end

    task automatic chk(input bit good, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // every-cycle comparison against the model (R1, R6, covers R3 R4 R5 R8)
    always @(negedge clk) begin
        if (live) begin
            chk(clk_pulse == m_pulse, "R6", "pulse vs model", clk_pulse, m_pulse);
            chk(cfg_rdata == m_reg, "R1", "readback vs model", cfg_rdata, m_reg);
        end
    end

    function automatic logic [31:0] mk(input bit en, input int sel, input int pd,
                                       input int dv, input bit b7);
        return (32'(en) << 15) | (32'(sel) << 13) | (32'(pd) << 8) | 32'(dv) | (32'(b7) << 7);
    endfunction

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drive now (caller sits at a negedge), consume one negedge
    task automatic wr_now(input logic [31:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            n++;
            if (clk_pulse) return;
        end
        n = -1;
    endtask

    task automatic count_pulses(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (clk_pulse) n++;
        end
    endtask

    task automatic interval_chk(input string req, input logic [31:0] w, input int exp);
        int n;
        wr(w);
        wait_pulse(n);
        wait_pulse(n);
        wait_pulse(n);
        chk(n == exp, req, "output interval", n, exp);
    endtask

    initial begin
        int n, a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(cfg_rdata == 32'h0, "R9", "reset word", cfg_rdata, 0);
        chk(clk_pulse == 1'b0, "R9", "reset pulse", clk_pulse, 0);
        live = 1'b1;
        count_pulses(20, n);
        chk(n == 0, "R9", "pulses after reset", n, 0);

        // R1 full-word readback including bit 7
        wr(32'hA5A5_5AFF);
        chk(cfg_rdata == 32'hA5A5_5AFF, "R1", "readback", cfg_rdata, 32'hA5A5_5AFF);
        wr(32'h0);
        repeat (3) @(negedge clk);

        // R7 start latency: code 1, div 1, source every cycle
        cfg_we = 1'b1; cfg_wdata = mk(1, 0, 1, 1, 0);
        @(negedge clk);
        cfg_we = 1'b0;
        wait_pulse(n);
        chk(n == 3, "R7", "first pulse edges after write", n, 3);

        // R4 predivide 2 and 3; R6 divide values
        interval_chk("R4", mk(1, 0, 1, 3, 0), 6);
        interval_chk("R4", mk(1, 0, 3, 1, 0), 3);
        interval_chk("R6", mk(1, 0, 3, 5, 0), 15);
        // R5 half predivide
        interval_chk("R5", mk(1, 0, 2, 2, 0), 5);
        wr(mk(1, 0, 2, 1, 0));
        wait_pulse(a); wait_pulse(a); wait_pulse(b);
        chk(a + b == 5, "R5", "pair of intervals sum", a + b, 5);
        chk((a == 2 && b == 3) || (a == 3 && b == 2), "R5", "alternating interval", a, 5 - b);

        // R3 source select
        interval_chk("R3", mk(1, 2, 1, 1, 0), 4);
        interval_chk("R3", mk(1, 3, 1, 1, 0), 6);
        interval_chk("R3", mk(1, 1, 1, 3, 0), 6);

        // R8 real change right after a pulse: closing pulse suppressed
        wr(mk(1, 0, 1, 3, 0));
        wait_pulse(n); wait_pulse(n);
        wr_now(mk(1, 0, 3, 1, 0));
        wait_pulse(n);
        chk(n + 1 == 9, "R8", "interval across a change", n + 1, 9);
        // R8 00 <-> 01 and bit 7 are not a change
        wr(mk(1, 0, 1, 3, 0));
        wait_pulse(n); wait_pulse(n);
        wr_now(mk(1, 1, 1, 3, 1));
        wait_pulse(n);
        chk(n + 1 == 6, "R8", "interval with no real change", n + 1, 6);

        // R2 disable conditions
        wait_pulse(n);
        wr_now(mk(0, 0, 1, 3, 0));
        count_pulses(40, n);
        chk(n == 0, "R2", "pulses with enable clear", n, 0);
        wr(mk(1, 0, 0, 3, 0));
        count_pulses(40, n);
        chk(n == 0, "R2", "pulses with predivide 0", n, 0);
        wr(mk(1, 0, 2, 0, 0));
        count_pulses(40, n);
        chk(n == 0, "R2", "pulses with divide 0", n, 0);
        interval_chk("R2", mk(1, 0, 1, 2, 0), 4);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule